// File: doc/BRIEF.md
# Pulse Channel with Sweep

This block produces a square-wave tone as a stream of 4-bit amplitude samples, one sample per system clock. Software programs it through four byte-wide registers, written with an address and a strobe. The registers set the duty shape, the volume source, the sweep settings and the 11-bit tone period. A write to the top register also loads a length count. The waveform comes from an eight-step sequencer. A down-counting timer advances it once every 2*(period+1) clocks. The sequencer's high steps carry the current volume, and its low steps carry zero.

Two strobe inputs from an external frame sequencer drive the slow units. The quarter-rate strobe clocks the decaying volume envelope. The half-rate strobe clocks the length counter and the sweep unit. The sweep unit can bend the pitch over time by rewriting the channel's own period register. It moves the period up or down by a shifted copy of itself. The channel goes silent when the period is too short, when a sweep step upwards would overflow the 11-bit range, or when the length count has run out. A parameter picks how a downward step is formed. One setting subtracts one extra count (one's-complement style). The other subtracts the plain offset (two's-complement style).

Top module: `pulse_tone_gen`

## Requirements
- R1: While rst_n is low, and on the first cycles after it rises, sample_out is 0. All counters, registers and the sequencer step clear to zero.
- R2: The period P is register 2 (low byte) joined with register 3 bits 2:0 (high bits). The sequencer step advances by one, modulo 8, once every 2*(P+1) clocks. The timer reloads with 2P+1 each time it reaches zero.
- R3: Register 0 bits 7:6 select the duty. Codes 0, 1 and 2 output the volume on steps below 1, 2 and 4 respectively. Code 3 outputs the volume on steps 2 to 7. All other steps output 0.
- R4: sample_out is 0 when P < 8, or when the length count is 0. It is also 0 when register 1 bit 3 is clear and P + (P >> register 1 bits 2:0) is 2048 or more.
- R5: A write to register 3 loads the length count from data bits 7:3. Each half-rate strobe decrements a nonzero count, unless register 0 bit 5 (halt) is set.
- R6: A write to register 3 arms a restart. The next quarter-rate strobe then sets the decay level to 15, loads the envelope divider from register 0 bits 3:0, and clears the restart.
- R7: On a quarter-rate strobe with no restart pending, a zero divider reloads. The decay level then steps down by one. At 0 it stays at 0, unless register 0 bit 5 is set, in which case it wraps to 15. A nonzero divider simply decrements.
- R8: When register 0 bit 4 is set, the volume is register 0 bits 3:0. Otherwise it is the decay level.
- R9: On a half-rate strobe with the sweep divider at 0, the period is replaced by the sweep target. This happens only if register 1 bit 7 is set, the shift (bits 2:0) is nonzero, P >= 8 and the target is below 2048. Otherwise the period is left unchanged.
- R10: The sweep target is P + (P >> shift) when register 1 bit 3 is clear. When it is set, the target is P - (P >> shift) - 1 if NEG_ONES_COMP is 1, and P - (P >> shift) if it is 0.
- R11: The sweep divider reloads from register 1 bits 6:4 on a half-rate strobe when it is 0, or when register 1 was written since the last half-rate strobe. Otherwise it decrements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the tone timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select, 0 to 3 |
| wr_data | input | 8 | Register write data |
| qtr_tick | input | 1 | Quarter-rate strobe, clocks the envelope |
| half_tick | input | 1 | Half-rate strobe, clocks length and sweep |
| sample_out | output | 4 | Amplitude sample |

## Verification
The hardest state to reach is a sweep write-back that lands exactly at the overflow edge. That needs an enabled sweep, a nonzero shift, a divider that has counted down to zero and a period close to 2048, all at the same time. Only a chain of half-rate strobes after the right register writes gets there. The stimulus sets periods near 1024 with shift 1 and divider reload 0, then issues half-rate strobes back to back. This drives the period upward step by step until the target crosses the limit and muting takes over. It also runs negate mode from small periods down towards the short-period threshold. A reference model in the bench tracks every register and compares the sample on every cycle.

// File: rtl/pulse_pkg.sv
package pulse_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_SWEEP = 2'd1,
      SEL_PLO   = 2'd2,
      SEL_PHI   = 2'd3
   } pulse_sel_e;

   localparam int unsigned STEPS   = 8;
   localparam int unsigned STEP_W  = 3;
   localparam int unsigned VOL_W   = 4;
   localparam int unsigned LEN_W   = 5;

   // Duty lookup: high for the step positions the duty code selects.
   function automatic logic duty_high(input logic [1:0] code, input logic [STEP_W-1:0] step);
      logic r;
      case (code)
         2'd0:    r = (step < 3'd1);
         2'd1:    r = (step < 3'd2);
         2'd2:    r = (step < 3'd4);
         default: r = !(step < 3'd2);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pulse_seq.sv
module pulse_seq
   import pulse_pkg::*;
#(
   parameter int unsigned PERIOD_W = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] period,
   input  logic [1:0]          duty_code,
   output logic                wave_hi
);
   localparam int unsigned TMR_W = PERIOD_W + 1;

   logic [TMR_W-1:0]  tmr_q;
   logic [STEP_W-1:0] step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q  <= '0;
         step_q <= '0;
      end else if (tmr_q == '0) begin
         tmr_q  <= {period, 1'b1};
         step_q <= step_q + 1'b1;
      end else begin
         tmr_q  <= tmr_q - 1'b1;
      end
   end

   assign wave_hi = duty_high(duty_code, step_q);

endmodule

// File: rtl/pulse_env.sv
module pulse_env
   import pulse_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qtr_tick,
   input  logic             restart_set,
   input  logic [3:0]       rate,
   input  logic             loop_en,
   output logic [VOL_W-1:0] level,
   output logic             restart
);
   logic [3:0]       div_q;
   logic [VOL_W-1:0] lvl_q;
   logic             rst_flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         lvl_q <= '0;
      end else if (qtr_tick) begin
         if (rst_flag_q) begin
            div_q <= rate;
            lvl_q <= '1;
         end else if (div_q == '0) begin
            div_q <= rate;
            if (lvl_q != '0)
               lvl_q <= lvl_q - 1'b1;
            else if (loop_en)
               lvl_q <= '1;
         end else begin
            div_q <= div_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rst_flag_q <= 1'b0;
      else if (restart_set)
         rst_flag_q <= 1'b1;
      else if (qtr_tick)
         rst_flag_q <= 1'b0;
   end

   assign level   = lvl_q;
   assign restart = rst_flag_q;

endmodule

// File: rtl/pulse_sweep.sv
module pulse_sweep #(
   parameter int unsigned PERIOD_W      = 11,
   parameter int unsigned MIN_PERIOD    = 8,
   parameter bit          NEG_ONES_COMP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                half_tick,
   input  logic                cfg_wr,
   input  logic [7:0]          cfg,
   input  logic [PERIOD_W-1:0] period,
   output logic                upd_en,
   output logic [PERIOD_W-1:0] upd_period,
   output logic                add_ovf
);
   localparam int unsigned TGT_W = PERIOD_W + 1;

   logic [2:0]          div_q;
   logic                reload_q;
   logic                sw_en, sw_neg;
   logic [2:0]          sw_rate, sw_shift;
   logic [PERIOD_W-1:0] offset;
   logic [TGT_W-1:0]    sum, diff, target;

   assign sw_en    = cfg[7];
   assign sw_rate  = cfg[6:4];
   assign sw_neg   = cfg[3];
   assign sw_shift = cfg[2:0];
   assign offset   = period >> sw_shift;
   assign sum      = {1'b0, period} + {1'b0, offset};

   generate
      if (NEG_ONES_COMP) begin : g_ones
         assign diff = {1'b0, period} - {1'b0, offset} - {{PERIOD_W{1'b0}}, 1'b1};
      end else begin : g_twos
         assign diff = {1'b0, period} - {1'b0, offset};
      end
   endgenerate

   assign target     = sw_neg ? diff : sum;
   assign add_ovf    = !sw_neg && sum[PERIOD_W];
   assign upd_period = target[PERIOD_W-1:0];
   assign upd_en     = half_tick && (div_q == 3'd0) && sw_en && (sw_shift != 3'd0)
                       && (period >= PERIOD_W'(MIN_PERIOD)) && !target[PERIOD_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= 3'd0;
      else if (half_tick) begin
         if (div_q == 3'd0 || reload_q)
            div_q <= sw_rate;
         else
            div_q <= div_q - 3'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reload_q <= 1'b0;
      else if (cfg_wr)
         reload_q <= 1'b1;
      else if (half_tick)
         reload_q <= 1'b0;
   end

endmodule

// File: rtl/pulse_tone_gen.sv
module pulse_tone_gen
   import pulse_pkg::*;
#(
   parameter int unsigned PERIOD_W      = 11,
   parameter int unsigned MIN_PERIOD    = 8,
   parameter bit          NEG_ONES_COMP = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       qtr_tick,
   input  logic       half_tick,
   output logic [3:0] sample_out
);
   localparam int unsigned HI_W = PERIOD_W - 8;

   if (PERIOD_W < 9 || PERIOD_W > 11) begin : g_bad_width
      $error("pulse_tone_gen: PERIOD_W must be 9 to 11");
   end
   if (MIN_PERIOD < 1 || MIN_PERIOD >= (1 << PERIOD_W)) begin : g_bad_min
      $error("pulse_tone_gen: MIN_PERIOD out of range");
   end

   logic [7:0]          ctrl_q, sweep_q;
   logic [PERIOD_W-1:0] period_q, period_d;
   logic [LEN_W-1:0]    len_q;
   logic                wr_ctrl, wr_sweep, wr_plo, wr_phi;
   logic                sw_upd, sw_ovf, wave_hi, env_restart, muted;
   logic [PERIOD_W-1:0] sw_period;
   logic [VOL_W-1:0]    env_level, volume;

   assign wr_ctrl  = wr_en && (wr_addr == SEL_CTRL);
   assign wr_sweep = wr_en && (wr_addr == SEL_SWEEP);
   assign wr_plo   = wr_en && (wr_addr == SEL_PLO);
   assign wr_phi   = wr_en && (wr_addr == SEL_PHI);

   always_comb begin
      period_d = sw_upd ? sw_period : period_q;
      if (wr_plo)
         period_d[7:0] = wr_data;
      if (wr_phi)
         period_d[PERIOD_W-1:8] = wr_data[HI_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         sweep_q  <= '0;
         period_q <= '0;
      end else begin
         if (wr_ctrl)
            ctrl_q <= wr_data;
         if (wr_sweep)
            sweep_q <= wr_data;
         period_q <= period_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len_q <= '0;
      else if (wr_phi)
         len_q <= wr_data[7:3];
      else if (half_tick && len_q != '0 && !ctrl_q[5])
         len_q <= len_q - 1'b1;
   end

   pulse_seq #(.PERIOD_W(PERIOD_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .period    (period_q),
      .duty_code (ctrl_q[7:6]),
      .wave_hi   (wave_hi)
   );

   pulse_env u_env (
      .clk         (clk),
      .rst_n       (rst_n),
      .qtr_tick    (qtr_tick),
      .restart_set (wr_phi),
      .rate        (ctrl_q[3:0]),
      .loop_en     (ctrl_q[5]),
      .level       (env_level),
      .restart     (env_restart)
   );

   pulse_sweep #(
      .PERIOD_W      (PERIOD_W),
      .MIN_PERIOD    (MIN_PERIOD),
      .NEG_ONES_COMP (NEG_ONES_COMP)
   ) u_sweep (
      .clk        (clk),
      .rst_n      (rst_n),
      .half_tick  (half_tick),
      .cfg_wr     (wr_sweep),
      .cfg        (sweep_q),
      .period     (period_q),
      .upd_en     (sw_upd),
      .upd_period (sw_period),
      .add_ovf    (sw_ovf)
   );

   assign volume     = ctrl_q[4] ? ctrl_q[3:0] : env_level;
   assign muted      = (period_q < PERIOD_W'(MIN_PERIOD)) || sw_ovf || (len_q == '0);
   assign sample_out = (muted || !wave_hi) ? '0 : volume;

endmodule

// File: rtl/pulse_tone_gen_chk.sv
module pulse_tone_gen_chk #(
   parameter int unsigned PERIOD_W   = 11,
   parameter int unsigned MIN_PERIOD = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [1:0]          wr_addr,
   input logic                qtr_tick,
   input logic                half_tick,
   input logic [PERIOD_W-1:0] period_q,
   input logic [4:0]          len_q,
   input logic [3:0]          env_level,
   input logic                env_restart,
   input logic [3:0]          sample_out
);
   // R4: a too-short period silences the output
   p_short_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (period_q < PERIOD_W'(MIN_PERIOD)) |-> (sample_out == 4'd0));

   // R4: an exhausted length count silences the output
   p_len_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q == 5'd0) |-> (sample_out == 4'd0));

   // R5: the length count moves only on a half strobe or a load
   p_len_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!half_tick && !(wr_en && wr_addr == 2'd3)) |=> $stable(len_q));

   // R6: an armed restart yields full level after the quarter strobe
   p_env_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (qtr_tick && env_restart) |=> (env_level == 4'hF));

   // R7: the decay level never changes without a quarter strobe
   p_env_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !qtr_tick |=> $stable(env_level));

   // R9: the period changes only through a write or a half strobe
   p_period_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!half_tick && !wr_en) |=> $stable(period_q));

endmodule

bind pulse_tone_gen pulse_tone_gen_chk #(
   .PERIOD_W   (PERIOD_W),
   .MIN_PERIOD (MIN_PERIOD)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .qtr_tick    (qtr_tick),
   .half_tick   (half_tick),
   .period_q    (period_q),
   .len_q       (len_q),
   .env_level   (env_level),
   .env_restart (env_restart),
   .sample_out  (sample_out)
);

// File: tb/pulse_tone_gen_test.sv
module pulse_tone_gen_test;
   localparam bit ONES = 1'b1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       qtr_tick = 1'b0;
   logic       half_tick = 1'b0;
   logic [3:0] sample_out;

   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc = 0;
   bit   done = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   pulse_tone_gen #(.NEG_ONES_COMP(ONES)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .qtr_tick(qtr_tick), .half_tick(half_tick), .sample_out(sample_out)
   );

   // reference state built from the requirements
   logic [7:0]  m_ctrl, m_sw;
   logic [10:0] m_per;
   logic [4:0]  m_len;
   logic [3:0]  m_ediv, m_elev;
   logic        m_erst, m_srel;
   logic [2:0]  m_sdiv, m_step;
   int          m_tmr;

   function automatic int sweep_target(input logic [10:0] p, input logic [7:0] s);
      int off;
      off = int'(p) >> s[2:0];
      if (!s[3]) return int'(p) + off;
      return int'(p) - off - (ONES ? 1 : 0);
   endfunction

   function automatic logic [3:0] expect_sample();
      logic hi, mute;
      int   w;
      mute = (m_per < 11'd8) || (m_len == 5'd0) ||
             (!m_sw[3] && (int'(m_per) + (int'(m_per) >> m_sw[2:0])) >= 2048);
      w = (m_ctrl[7:6] == 2'd3) ? 2 : (1 << m_ctrl[7:6]);
      hi = (int'(m_step) < w);
      if (m_ctrl[7:6] == 2'd3) hi = !hi;
      if (mute || !hi) return 4'd0;
      return m_ctrl[4] ? m_ctrl[3:0] : m_elev;
   endfunction

   always @(posedge clk) begin
      int tgt;
      bit upd;
      if (!rst_n) begin
         m_ctrl = 0; m_sw = 0; m_per = 0; m_len = 0; m_ediv = 0; m_elev = 0;
         m_erst = 0; m_srel = 0; m_sdiv = 0; m_step = 0; m_tmr = 0;
      end else begin
         tgt = sweep_target(m_per, m_sw);
         upd = 1'b0;
         if (half_tick) begin
            if (m_sdiv == 0) begin
               upd = m_sw[7] && (m_sw[2:0] != 0) && (m_per >= 8) && (tgt < 2048);
               m_sdiv = m_sw[6:4];
            end else if (m_srel) m_sdiv = m_sw[6:4];
            else m_sdiv = m_sdiv - 1;
            m_srel = 0;
            if (m_len != 0 && !m_ctrl[5]) m_len = m_len - 1;
         end
         if (qtr_tick) begin
            if (m_erst) begin m_ediv = m_ctrl[3:0]; m_elev = 15; m_erst = 0; end
            else if (m_ediv == 0) begin
               m_ediv = m_ctrl[3:0];
               if (m_elev != 0) m_elev = m_elev - 1;
               else if (m_ctrl[5]) m_elev = 15;
            end else m_ediv = m_ediv - 1;
         end
         if (m_tmr == 0) begin m_tmr = 2 * int'(m_per) + 1; m_step = m_step + 1; end
         else m_tmr = m_tmr - 1;
         if (upd) m_per = tgt[10:0];
         if (wr_en) begin
            case (wr_addr)
               2'd0: m_ctrl = wr_data;
               2'd1: begin m_sw = wr_data; m_srel = 1; end
               2'd2: m_per[7:0] = wr_data;
               default: begin m_per[10:8] = wr_data[2:0]; m_len = wr_data[7:3]; m_erst = 1; end
            endcase
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      logic [3:0] exp_s;
      if (!done) begin
         exp_s = rst_n ? expect_sample() : 4'd0;
         n_chk++;
         if (sample_out !== exp_s) begin
            n_bad++;
            if (n_bad < 20)
               $display("FAIL %s cycle %0d: sample_out=%0d expected=%0d", cur_req, cyc, sample_out, exp_s);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: cycles=%0d expected completion before 190000", cyc);
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick(input bit q, input bit h);
      @(negedge clk);
      qtr_tick = q; half_tick = h;
      @(negedge clk);
      qtr_tick = 1'b0; half_tick = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      cur_req = "R1";
      idle(5);
      rst_n = 1'b1;
      idle(5);

      // R2 / R3: each duty code at a few periods, constant volume, halted length
      wr(2'd1, 8'h08);                         // negate so no overflow mute
      for (int dc = 0; dc < 4; dc++) begin
         cur_req = "R3";
         wr(2'd0, {dc[1:0], 6'b11_1001});      // halt, constant 9
         for (int k = 0; k < 3; k++) begin
            cur_req = "R2";
            wr(2'd2, (k == 0) ? 8'd8 : (k == 1) ? 8'd37 : 8'd200);
            wr(2'd3, {5'd20, 3'd0});
            idle(8 * 2 * 210);
         end
      end

      // R4: short period threshold and overflow mute
      cur_req = "R4";
      wr(2'd0, 8'hBA);
      wr(2'd2, 8'd7); wr(2'd3, {5'd9, 3'd0}); idle(200);
      wr(2'd2, 8'd8); idle(200);
      wr(2'd1, 8'h00);                          // add mode, shift 0: P+P
      wr(2'd2, 8'h00); wr(2'd3, {5'd9, 3'd4}); idle(300);   // 1024 -> muted
      wr(2'd2, 8'hFF); wr(2'd3, {5'd9, 3'd3}); idle(300);   // 1023 -> audible
      wr(2'd1, 8'h01); wr(2'd2, 8'h56); wr(2'd3, {5'd9, 3'd5}); idle(300); // 1366 shift1 -> 2049
      wr(2'd2, 8'h54); idle(300);                            // 1364 -> 2046

      // R5: length runs out without halt
      cur_req = "R5";
      wr(2'd0, 8'hDC);                          // no halt, constant 12
      wr(2'd1, 8'h08); wr(2'd2, 8'd12); wr(2'd3, {5'd3, 3'd0});
      for (int k = 0; k < 5; k++) begin tick(0, 1); idle(60); end
      wr(2'd0, 8'hFC); wr(2'd3, {5'd2, 3'd0});
      for (int k = 0; k < 3; k++) begin tick(0, 1); idle(60); end

      // R6 / R7: envelope decay, no loop then loop
      cur_req = "R6";
      wr(2'd0, 8'hC0);                          // duty 3, decay, rate 0, no loop
      wr(2'd2, 8'd9); wr(2'd3, {5'd31, 3'd0});
      tick(1, 0); idle(40);
      cur_req = "R7";
      for (int k = 0; k < 18; k++) begin tick(1, 0); idle(40); end
      wr(2'd0, 8'hE1);                          // loop, rate 1 (also halts length)
      for (int k = 0; k < 40; k++) begin tick(1, 0); idle(40); end

      // R8: constant volume overrides decay level
      cur_req = "R8";
      wr(2'd0, 8'hD5); idle(100);
      wr(2'd0, 8'hDF); idle(100);

      // R9 / R11: sweep up from near 1024 until the overflow limit
      cur_req = "R9";
      wr(2'd0, 8'hFA);
      wr(2'd2, 8'h10); wr(2'd3, {5'd31, 3'd4});
      wr(2'd1, 8'h81);                          // enable, rate 0, shift 1
      for (int k = 0; k < 4; k++) begin tick(0, 1); idle(100); end
      cur_req = "R11";
      wr(2'd2, 8'h40); wr(2'd3, {5'd31, 3'd1});
      wr(2'd1, 8'hB2);                          // rate 3, shift 2
      for (int k = 0; k < 12; k++) begin tick(0, 1); idle(100); end

      // R10: negate sweep down to the short threshold
      cur_req = "R10";
      wr(2'd2, 8'd40); wr(2'd3, {5'd31, 3'd0});
      wr(2'd1, 8'h89);
      for (int k = 0; k < 10; k++) begin tick(0, 1); idle(60); end

      // random mix
      cur_req = "R10";
      for (int k = 0; k < 3000; k++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r < 2) wr(2'($urandom_range(0, 3)), 8'($urandom));
         else if (r < 4) tick(1'($urandom), 1'($urandom));
         else idle($urandom_range(1, 20));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule